// File: doc/BRIEF.md
# Set-Clear GPIO Port Controller

This block is a general-purpose I/O port of 32 pins sitting on a simple word-addressed register bus. Every pin has an output latch bit and a direction bit. Software never writes the latch directly. It writes a mask to a set register or to a clear register instead. Any pin named in either of those writes also starts driving its pad. A third register returns named pins to input (high-impedance) mode.

Pad levels reach software through a two-flop synchronizer. The pin-state view stays dark after reset until software has written the pin-state register once; the value written does not matter. After that one write the input path stays armed until the next reset. On the pad side the block drives one output-enable and one output-value line per pin. The pad cells themselves sit outside the block.

Reads are registered. A read accepted on one clock edge returns its data, marked valid, one cycle later. The asynchronous active-low reset is released inside the block two clock edges after the input deasserts.

Top module: `sc_gpio_port`

## Requirements
- R1: After reset every pin is an input (pad_oe all 0), the latch is 0 (pad_out all 0), and reading the direction register at 0x100 returns all ones, where a 1 bit means the pin is an input.
- R2: A write to 0x108 sets the latch bit of each pin whose data bit is 1 and leaves the other latch bits alone. Reading 0x108 returns the latch.
- R3: A write to 0x10C clears the latch bit of each pin whose data bit is 1 and leaves the other latch bits alone. Reading 0x10C returns 0.
- R4: Each pin written with a 1 to 0x108 or 0x10C becomes an output (pad_oe bit 1). Pins written with 0 keep their direction.
- R5: A write to 0x100 makes each pin whose data bit is 1 an input and leaves the other pins' direction unchanged. The latch is not altered.
- R6: pad_out always equals the latch, whatever the direction, and pad_oe is the inverse of the direction bits.
- R7: Until 0x110 has been written at least once since reset, reading 0x110 returns 0 whatever the pad levels are.
- R8: Once armed, reading 0x110 returns pad_in through two synchronizer flops. A pad change just before edge E1 is seen by a read accepted at edge E3 but not by one accepted at E1 or E2.
- R9: Writes to unmapped offsets change neither the latch nor the direction, and reads of them return 0.
- R10: Arming is sticky until reset. Writing 0x110 with any data, including 0, arms the path and changes neither the latch nor the direction.
- R11: Read data appears on bus_rdata with bus_rvalid high exactly one cycle after a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | 32 | External pin levels |
| pad_out | output | 32 | Pad output values (the latch) |
| pad_oe | output | 32 | Pad output enables, 1 = drive |

## Verification
The bench clears a pin whose latch is already 0 but which is still an input. A design that updated the direction only on the set register would leave that pad floating. It sends a direction write that names only some pins. This catches a design that overwrites the whole direction register or disturbs the latch.

The bench reads the pin state while pads toggle before arming, then arms with a data value of 0. This exposes a design that arms on nonzero data only, or that leaks pad levels early. It issues three back-to-back reads right after a pad change and expects the new level on the third read only. A missing or extra synchronizer stage shows up as the change arriving on the wrong read. Writes and reads at unmapped offsets catch decode aliasing, and pin 31 is exercised as the edge bit.

// File: rtl/sc_gpio_pkg.sv
package sc_gpio_pkg;
  // one-hot register selects produced by the decoder
  typedef struct packed {
    logic dir_s;   // direction register (1 = input)
    logic set_s;   // latch set / latch readback
    logic clr_s;   // latch clear
    logic pin_s;   // pin state / arming
  } gpio_sel_t;
endpackage

// File: rtl/sc_gpio_rst_sync.sv
module sc_gpio_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/sc_gpio_decode.sv
module sc_gpio_decode
  import sc_gpio_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int OFS_DIR = 'h100,
  parameter int OFS_SET = 'h108,
  parameter int OFS_CLR = 'h10C,
  parameter int OFS_PIN = 'h110
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_sel_t         sel
);
  always_comb begin
    sel.dir_s = (addr == ADDR_W'(OFS_DIR));
    sel.set_s = (addr == ADDR_W'(OFS_SET));
    sel.clr_s = (addr == ADDR_W'(OFS_CLR));
    sel.pin_s = (addr == ADDR_W'(OFS_PIN));
  end
endmodule

// File: rtl/sc_gpio_sync.sv
module sc_gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = din;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sc_gpio_pin_bank.sv
module sc_gpio_pin_bank #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                set_we,
  input  logic                clr_we,
  input  logic                dir_we,
  input  logic [NUM_PINS-1:0] mask,
  output logic [NUM_PINS-1:0] latch,
  output logic [NUM_PINS-1:0] dir_in
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic lat_q, lat_d, lat_en;
    logic dir_q, dir_d, dir_en;

    // latch: clear has priority over set
    always_comb begin
      lat_en = mask[p] & (set_we | clr_we);
      lat_d  = clr_we ? 1'b0 : 1'b1;
    end

    // direction: set/clear access makes the pin drive, dir write releases it
    always_comb begin
      dir_en = mask[p] & (set_we | clr_we | dir_we);
      dir_d  = dir_we & ~(set_we | clr_we);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     lat_q <= 1'b0;
      else if (lat_en) lat_q <= lat_d;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     dir_q <= 1'b1;
      else if (dir_en) dir_q <= dir_d;
    end

    assign latch[p]  = lat_q;
    assign dir_in[p] = dir_q;
  end
endmodule

// File: rtl/sc_gpio_port.sv
module sc_gpio_port
  import sc_gpio_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_DIR     = 'h100,
  parameter int OFS_SET     = 'h108,
  parameter int OFS_CLR     = 'h10C,
  parameter int OFS_PIN     = 'h110
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  logic                rst_sync_n;
  gpio_sel_t           sel;
  logic [NUM_PINS-1:0] latch, dir_in, pin_sync;
  logic                armed_q, armed_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                rvalid_q;

  sc_gpio_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_sync_n));

  sc_gpio_decode #(
    .ADDR_W(ADDR_W), .OFS_DIR(OFS_DIR), .OFS_SET(OFS_SET),
    .OFS_CLR(OFS_CLR), .OFS_PIN(OFS_PIN)
  ) u_dec (.addr(bus_addr), .sel(sel));

  sc_gpio_pin_bank #(.NUM_PINS(NUM_PINS)) u_bank (
    .clk(clk), .rst_ni(rst_sync_n),
    .set_we(bus_wr & sel.set_s), .clr_we(bus_wr & sel.clr_s),
    .dir_we(bus_wr & sel.dir_s), .mask(bus_wdata[NUM_PINS-1:0]),
    .latch(latch), .dir_in(dir_in)
  );

  sc_gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ni(rst_sync_n), .din(pad_in), .dout(pin_sync)
  );

  // arming is sticky: any write to the pin-state offset
  always_comb armed_d = armed_q | (bus_wr & sel.pin_s);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed_q <= 1'b0;
    else             armed_q <= armed_d;
  end

  // registered read mux
  always_comb begin
    rdata_d = '0;
    unique case (1'b1)
      sel.dir_s: rdata_d = DATA_W'(dir_in);
      sel.set_s: rdata_d = DATA_W'(latch);
      sel.pin_s: rdata_d = armed_q ? DATA_W'(pin_sync) : '0;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign pad_out    = latch;
  assign pad_oe     = ~dir_in;
endmodule

// File: rtl/sc_gpio_port_chk.sv
module sc_gpio_port_chk #(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int OFS_DIR  = 'h100,
  parameter int OFS_SET  = 'h108,
  parameter int OFS_CLR  = 'h10C,
  parameter int OFS_PIN  = 'h110
) (
  input logic                clk,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                bus_rvalid,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                armed
);
  logic wr_set, wr_clr, wr_dir, rd_map;
  logic [NUM_PINS-1:0] m;
  assign wr_set = bus_wr && bus_addr == ADDR_W'(OFS_SET);
  assign wr_clr = bus_wr && bus_addr == ADDR_W'(OFS_CLR);
  assign wr_dir = bus_wr && bus_addr == ADDR_W'(OFS_DIR);
  assign rd_map = bus_addr == ADDR_W'(OFS_DIR) || bus_addr == ADDR_W'(OFS_SET) ||
                  bus_addr == ADDR_W'(OFS_PIN);
  assign m = bus_wdata[NUM_PINS-1:0];

  p_set_latch_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_set |=> ((pad_out & $past(m)) == $past(m)));
  p_clr_latch_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_clr |=> ((pad_out & $past(m)) == '0));
  p_drive_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_set || wr_clr) |=> ((pad_oe & $past(m)) == $past(m)));
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_dir |=> ((pad_oe & $past(m)) == '0));
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(pad_out));
  p_dark_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && bus_addr == ADDR_W'(OFS_PIN) && !armed) |=> (bus_rdata == '0));
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && !rd_map) |=> (bus_rdata == '0));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    armed |=> armed);
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_rd |=> bus_rvalid);
endmodule

bind sc_gpio_port sc_gpio_port_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_DIR(OFS_DIR),
  .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR), .OFS_PIN(OFS_PIN)
) u_chk (
  .clk(clk), .rst_ni(rst_sync_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .pad_out(pad_out), .pad_oe(pad_oe), .armed(armed_q)
);

// File: tb/test_sc_gpio_port.sv
`timescale 1ns/1ps
module test_sc_gpio_port;
  localparam int W = 32;
  localparam logic [11:0] A_DIR = 12'h100, A_SET = 12'h108,
                          A_CLR = 12'h10C, A_PIN = 12'h110;

  logic clk = 1'b0;
  logic rst_n;
  logic [11:0] bus_addr;
  logic bus_wr, bus_rd;
  logic [W-1:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic bus_rvalid;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] m_lat, m_dir;  // bench model

  always #4 clk = ~clk;

  sc_gpio_port i_sc_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pads(string req);
    check({req, " pad_out"}, pad_out, m_lat);
    check({req, " pad_oe"}, pad_oe, ~m_dir);
  endtask

  task automatic wr(logic [11:0] a, logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [W-1:0] exp, string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compare read results as they appear (R11 timing)
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R11 unexpected rvalid actual=1 expected=0");
      end else begin
        automatic logic [W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    pad_in = 32'hA5A5_5A5A;
    m_lat = '0; m_dir = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_pads("R1");
    rd(A_DIR, 32'hFFFF_FFFF, "R1 dir readback");
    rd(A_SET, 32'h0, "R2 latch after reset");
    rd(A_PIN, 32'h0, "R7 disarmed pin read");

    // R2 / R4 set
    wr(A_SET, 32'h0000_00F5); m_lat |= 32'hF5; m_dir &= ~32'hF5;
    check_pads("R2/R4 set");
    rd(A_SET, 32'h0000_00F5, "R2 latch readback");

    // R3 / R4 clear
    wr(A_CLR, 32'h0000_0014); m_lat &= ~32'h14; m_dir &= ~32'h14;
    check_pads("R3 clear");
    rd(A_CLR, 32'h0, "R3 clr read zero");

    // R4 clear of an input pin whose latch is already 0
    wr(A_CLR, 32'h0000_0100); m_dir &= ~32'h100;
    check_pads("R4 clr drives");

    // R5 partial release, latch kept; R6 pad_out independent of direction
    wr(A_DIR, 32'h0000_0005); m_dir |= 32'h5;
    check_pads("R5/R6 release");
    rd(A_DIR, m_dir, "R5 dir readback");

    // R2 edge pin 31
    wr(A_SET, 32'h8000_0000); m_lat |= 32'h8000_0000; m_dir &= ~32'h8000_0000;
    check_pads("R2 pin31");

    // R9 unmapped
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    check_pads("R9 unmapped write");
    rd(12'h104, 32'h0, "R9 unmapped read");
    rd(12'h000, 32'h0, "R9 unmapped read low");

    // R7 still dark with pads toggling
    pad_in = 32'h0F0F_F0F0;
    repeat (3) @(negedge clk);
    rd(A_PIN, 32'h0, "R7 dark before arm");

    // R10 arm with zero data
    wr(A_PIN, 32'h0);
    check_pads("R10 arm no side effect");
    rd(A_PIN, 32'h0F0F_F0F0, "R10 armed read");

    // R8 synchronizer depth
    pad_in = 32'h1234_5678;
    rd(A_PIN, 32'h0F0F_F0F0, "R8 edge1 old");
    rd(A_PIN, 32'h0F0F_F0F0, "R8 edge2 old");
    rd(A_PIN, 32'h1234_5678, "R8 edge3 new");

    // R10 sticky through other writes
    wr(A_DIR, 32'h0000_0010); m_dir |= 32'h10;
    wr(A_SET, 32'h0000_0002); m_lat |= 32'h2; m_dir &= ~32'h2;
    check_pads("R10 later writes");
    rd(A_PIN, 32'h1234_5678, "R10 sticky");

    repeat (3) @(negedge clk);
    check("R11 read queue drained", W'(exp_q.size()), '0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule